// File: doc/BRIEF.md
# Masked Frame Match Interrupt Unit

This unit sits next to an infrared frame decoder. Each time the decoder reports a completed 64-bit data word, the unit compares the word with a programmable pattern. Only the bit positions selected by a programmable mask take part in the compare. A hit raises a match event. The unit also collects three plain events from the decoder: a line edge, a completed frame on the primary decoder, and a completed frame on the second decoder.

Each event sets a sticky status bit. Each status bit has its own enable bit. The single interrupt line is asserted while any status bit is set together with its enable bit. Software clears status bits by writing ones to a clear register.

The pattern and the mask are each written as two 32-bit halves. An all-zero mask turns filtering off. In normal operation software enables only the data-valid sources. When filtering is active it enables only the match source. In a low-power wait state it enables only the match source, so that only a matching frame interrupts the host.

Top module: `irqm_top`

## Requirements
- R1: After reset every readable register reads zero and `irq_o` is low.
- R2: The registers are at these addresses: 0 is pattern bits 31:0, 1 is pattern bits 63:32, 2 is mask bits 31:0, 3 is mask bits 63:32, 4 is enable, 5 is status and 6 is clear. A write updates the register at the next clock edge. Reading address 6 or 7 returns zero.
- R3: Status and enable bits are assigned as follows: bit 0 is edge, bit 1 is primary data valid, bit 2 is second-decoder data valid, bit 3 is match. When `frame_done_i` is high, the mask is nonzero, and `(frame_data_i & mask) == (pattern & mask)`, status bit 3 is set at the next edge.
- R4: While the mask is all zero, no frame sets status bit 3.
- R5: A difference from the pattern in any masked bit blocks the match. A difference only in unmasked bits does not block it.
- R6: `rx_edge_i`, `frame_done_i` and `frame_done2_i` set status bits 0, 1 and 2 at the next edge, whatever the enable bits hold.
- R7: Writing to the clear register clears the status bits written as one and leaves the bits written as zero unchanged.
- R8: When an event and a clear of the same status bit fall in the same cycle, the bit stays set.
- R9: `irq_o` is high exactly when some status bit and its enable bit are both one. It follows writes to the enable and status registers in the same cycle they take effect.
- R10: `frame_data_i` is ignored while `frame_done_i` is low. Data that matches the pattern sets no status bit unless a frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Read data, combinational from the registers |
| rx_edge_i | input | 1 | Edge seen on the receive line |
| frame_done_i | input | 1 | Primary decoder completed a frame |
| frame_done2_i | input | 1 | Second decoder completed a frame |
| frame_data_i | input | 64 | Completed frame word, valid with `frame_done_i` |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench uses a frame that differs from the pattern only in bits outside the mask, and another that differs by a single bit inside the mask, once in the lower half and once in the upper half. A compare that ignores the mask, or one that swaps the halves, gets one of these cases wrong. The bench sends a matching frame under an all-zero mask; a unit without the nonzero-mask guard would report a match there. It drives a matching word without a frame strobe, and it lands a clear in the same cycle as a new event; a unit that gives the clear priority loses that event. It also checks that status bits latch while their enables are off, and that partial clears keep the interrupt up while another enabled bit remains set.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
    localparam int NSRC       = 4;
    localparam int SRC_EDGE   = 0;
    localparam int SRC_VALID  = 1;
    localparam int SRC_VALID2 = 2;
    localparam int SRC_MATCH  = 3;
endpackage

// File: rtl/irqm_cfg.sv
module irqm_cfg
    import irqm_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int NHALF  = 2,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [REG_W-1:0]         wr_data_i,
    output logic [REG_W*NHALF-1:0]   pat_o,
    output logic [REG_W*NHALF-1:0]   msk_o,
    output logic [NSRC-1:0]          en_o
);
    localparam int DATA_W = REG_W * NHALF;
    localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(2 * NHALF);

    typedef struct packed {
        logic [DATA_W-1:0] pat;
        logic [DATA_W-1:0] msk;
        logic [NSRC-1:0]   en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            for (int h = 0; h < NHALF; h++) begin
                if (wr_addr_i == ADDR_W'(h))
                    cfg_d.pat[h*REG_W +: REG_W] = wr_data_i;
                if (wr_addr_i == ADDR_W'(NHALF + h))
                    cfg_d.msk[h*REG_W +: REG_W] = wr_data_i;
            end
            if (wr_addr_i == EN_ADDR)
                cfg_d.en = wr_data_i[NSRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign pat_o = cfg_q.pat;
    assign msk_o = cfg_q.msk;
    assign en_o  = cfg_q.en;
endmodule

// File: rtl/irqm_cmp.sv
module irqm_cmp #(
    parameter int DATA_W = 64
) (
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] pat_i,
    input  logic [DATA_W-1:0] msk_i,
    output logic              hit_o
);
    logic [DATA_W-1:0] diff;
    logic              armed;

    always_comb begin
        diff  = (data_i ^ pat_i) & msk_i;
        armed = |msk_i;
        hit_o = strobe_i && armed && (diff == '0);
    end
endmodule

// File: rtl/irqm_stat.sv
module irqm_stat
    import irqm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            clr_we_i,
    input  logic [NSRC-1:0] clr_bits_i,
    input  logic [NSRC-1:0] en_i,
    output logic [NSRC-1:0] stat_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we_i)
            st_d.stat = st_d.stat & ~clr_bits_i;
        st_d.stat = st_d.stat | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign irq_o  = |(st_q.stat & en_i);
endmodule

// File: rtl/irqm_top.sv
module irqm_top
    import irqm_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int NHALF  = 2,
    parameter int ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [REG_W-1:0]       wr_data_i,
    input  logic [ADDR_W-1:0]      rd_addr_i,
    output logic [REG_W-1:0]       rd_data_o,
    input  logic                   rx_edge_i,
    input  logic                   frame_done_i,
    input  logic                   frame_done2_i,
    input  logic [REG_W*NHALF-1:0] frame_data_i,
    output logic                   irq_o
);
    localparam int DATA_W = REG_W * NHALF;
    localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(2 * NHALF);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(2 * NHALF + 1);
    localparam logic [ADDR_W-1:0] CLR_ADDR  = ADDR_W'(2 * NHALF + 2);

    logic [DATA_W-1:0] pat_w, msk_w;
    logic [NSRC-1:0]   en_w, stat_w, evt_w;
    logic              hit_w, clr_we_w;

    irqm_cfg #(.REG_W(REG_W), .NHALF(NHALF), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .pat_o(pat_w), .msk_o(msk_w), .en_o(en_w)
    );

    irqm_cmp #(.DATA_W(DATA_W)) u_cmp (
        .strobe_i(frame_done_i), .data_i(frame_data_i),
        .pat_i(pat_w), .msk_i(msk_w), .hit_o(hit_w)
    );

    always_comb begin
        evt_w             = '0;
        evt_w[SRC_EDGE]   = rx_edge_i;
        evt_w[SRC_VALID]  = frame_done_i;
        evt_w[SRC_VALID2] = frame_done2_i;
        evt_w[SRC_MATCH]  = hit_w;
        clr_we_w          = wr_en_i && (wr_addr_i == CLR_ADDR);
    end

    irqm_stat u_stat (
        .clk(clk), .rst_n(rst_n),
        .evt_i(evt_w), .clr_we_i(clr_we_w), .clr_bits_i(wr_data_i[NSRC-1:0]),
        .en_i(en_w), .stat_o(stat_w), .irq_o(irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        for (int h = 0; h < NHALF; h++) begin
            if (rd_addr_i == ADDR_W'(h))
                rd_data_o = pat_w[h*REG_W +: REG_W];
            if (rd_addr_i == ADDR_W'(NHALF + h))
                rd_data_o = msk_w[h*REG_W +: REG_W];
        end
        if (rd_addr_i == EN_ADDR)
            rd_data_o = REG_W'(en_w);
        if (rd_addr_i == STAT_ADDR)
            rd_data_o = REG_W'(stat_w);
    end
endmodule

// File: rtl/irqm_chk.sv
module irqm_chk
    import irqm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int REG_W  = 32,
    parameter int ADDR_W = 3,
    parameter int CLR_A  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [REG_W-1:0]  wr_data_i,
    input logic              frame_done_i,
    input logic [DATA_W-1:0] frame_data_i,
    input logic [DATA_W-1:0] pat,
    input logic [DATA_W-1:0] msk,
    input logic [NSRC-1:0]   stat,
    input logic              irq_o
);
    logic clr_valid, clr_match;
    assign clr_valid = wr_en_i && (wr_addr_i == ADDR_W'(CLR_A)) && wr_data_i[SRC_VALID];
    assign clr_match = wr_en_i && (wr_addr_i == ADDR_W'(CLR_A)) && wr_data_i[SRC_MATCH];

    assert_match_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && (msk != '0) && (((frame_data_i ^ pat) & msk) == '0)) |=> stat[SRC_MATCH]);

    assert_zero_mask_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((msk == '0) && !stat[SRC_MATCH]) |=> !stat[SRC_MATCH]);

    assert_valid_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_i |=> stat[SRC_VALID]);

    assert_clear_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !frame_done_i) |=> !stat[SRC_VALID]);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_match && frame_done_i && (msk != '0) && (((frame_data_i ^ pat) & msk) == '0))
        |=> stat[SRC_MATCH]);

    assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat != '0));

    assert_no_strobe_no_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done_i && !stat[SRC_MATCH]) |=> !stat[SRC_MATCH]);
endmodule

bind irqm_top irqm_chk #(
    .DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .CLR_A(2 * NHALF + 2)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .frame_done_i(frame_done_i), .frame_data_i(frame_data_i),
    .pat(pat_w), .msk(msk_w), .stat(stat_w), .irq_o(irq_o)
);

// File: tb/sim_irqm_top.sv
`timescale 1ns/1ps
module sim_irqm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rx_edge = 1'b0, fdone = 1'b0, fdone2 = 1'b0;
    logic [63:0] fdata = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic smp = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    irqm_top u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .rx_edge_i(rx_edge), .frame_done_i(fdone), .frame_done2_i(fdone2),
        .frame_data_i(fdata), .irq_o(irq)
    );

    // monitor: pops one expectation per sampling cycle
    always @(negedge clk) begin
        if (smp) begin
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL scoreboard empty");
            end else begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.is_irq ? {31'd0, irq} : rd_data;
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // all tasks start and end at posedge + 1
    task automatic step(input logic e, input logic d, input logic d2, input logic [63:0] data,
                        input logic we, input logic [2:0] wa, input logic [31:0] wd);
        rx_edge = e; fdone = d; fdone2 = d2; fdata = data;
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk); #1;
        rx_edge = 0; fdone = 0; fdone2 = 0; wr_en = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(0, 0, 0, fdata, 1, a, d);
    endtask

    task automatic frame(input logic [63:0] data);
        step(0, 1, 0, data, 0, 3'd0, 32'd0);
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string req);
        item_t it;
        it.is_irq = 0; it.exp = e; it.req = req;
        sb.push_back(it);
        rd_addr = a; smp = 1;
        @(posedge clk); #1;
        smp = 0;
    endtask

    task automatic exp_irq(input logic e, input string req);
        item_t it;
        it.is_irq = 1; it.exp = {31'd0, e}; it.req = req;
        sb.push_back(it);
        smp = 1;
        @(posedge clk); #1;
        smp = 0;
    endtask

    localparam logic [63:0] HIT = 64'hCAFE_ABCD_1234_5678;

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;

        for (int a = 0; a < 8; a++) exp_rd(3'(a), 32'd0, "R1 reset value");
        exp_irq(0, "R1 reset irq");

        wr(3'd0, 32'h1234_5678); wr(3'd1, 32'hCAFE_0000);
        wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_0000);
        exp_rd(3'd0, 32'h1234_5678, "R2 pattern low");
        exp_rd(3'd1, 32'hCAFE_0000, "R2 pattern high");
        exp_rd(3'd2, 32'hFFFF_FFFF, "R2 mask low");
        exp_rd(3'd3, 32'hFFFF_0000, "R2 mask high");

        frame(HIT);
        exp_rd(3'd5, 32'h0A, "R3 R5 match with unmasked difference");
        exp_irq(0, "R6 status latches with enables off");

        wr(3'd6, 32'h08);
        exp_rd(3'd5, 32'h02, "R7 partial clear");
        wr(3'd6, 32'h02);
        exp_rd(3'd5, 32'h00, "R7 second clear");

        frame(64'hCAFA_0000_1234_5678);
        exp_rd(3'd5, 32'h02, "R5 masked upper bit differs");
        wr(3'd6, 32'h0F);
        frame(64'hCAFE_0000_1234_5679);
        exp_rd(3'd5, 32'h02, "R5 masked lower bit differs");
        wr(3'd6, 32'h0F);

        wr(3'd2, 32'h0); wr(3'd3, 32'h0);
        frame(HIT);
        exp_rd(3'd5, 32'h02, "R4 zero mask no match");
        wr(3'd6, 32'h0F);
        wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_0000);

        step(0, 0, 0, HIT, 0, 3'd0, 32'd0);
        step(0, 0, 0, HIT, 0, 3'd0, 32'd0);
        exp_rd(3'd5, 32'h00, "R10 data without strobe");

        step(1, 0, 1, 64'd0, 0, 3'd0, 32'd0);
        exp_rd(3'd5, 32'h05, "R6 edge and second decoder");
        exp_irq(0, "R9 no enables");
        wr(3'd4, 32'h05);
        exp_rd(3'd4, 32'h05, "R2 enable readback");
        exp_irq(1, "R9 enabled status");
        wr(3'd6, 32'h01);
        exp_irq(1, "R9 other enabled bit remains");
        wr(3'd6, 32'h04);
        exp_irq(0, "R9 all cleared");

        wr(3'd4, 32'h08);
        frame(64'h0);
        exp_rd(3'd5, 32'h02, "R5 mismatch frame");
        exp_irq(0, "R9 valid not enabled");
        wr(3'd6, 32'h02);
        frame(HIT);
        exp_irq(1, "R9 match-only enable");
        wr(3'd6, 32'h0F);
        exp_irq(0, "R7 clear drops irq");

        step(0, 1, 0, HIT, 1, 3'd6, 32'h0A);
        exp_rd(3'd5, 32'h0A, "R8 set wins over clear");
        exp_irq(1, "R8 irq from kept match");
        wr(3'd6, 32'h0F);
        exp_rd(3'd5, 32'h00, "R7 final clear");
        exp_rd(3'd6, 32'h00, "R2 clear address reads zero");

        @(posedge clk); #1;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        summary();
    end
endmodule